// File: doc/BRIEF.md
# Flash status register and write-permission guard

This block holds the status register of a serial flash device and rules on every write-class command that the command decoder presents. The register holds five bits. A busy flag marks a status write, program or erase cycle in flight. An arming latch must be set before any write-class command is accepted. A two-bit protection level fences off an upper part of the array. A lock bit works with the active-low write-protect pin to freeze the register contents.

The decoder delivers one single-cycle command strobe at a time, along with the target address and, for a status write, the new data byte. One cycle later the block answers with a single-cycle grant pulse for each command it accepts. The cycle engine receives that grant, and when the cycle has finished it reports with a done pulse. The status byte is a continuous output, so it can be shifted out at any moment, even while a cycle is running.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and no grant is asserted.
- R2: The status byte is always readable. Bit 0 is busy, bit 1 is the arming latch, bits 3:2 are the protection level and bit 7 is the lock bit. Bits 6:4 always read 0. Busy reads 1 while a granted cycle is outstanding or while `eng_busy` is high.
- R3: `cmd_wren` sets the arming latch and `cmd_wrdi` clears it. Both have no effect while busy reads 1 or while `eng_done` is high.
- R4: A status write, program, sector erase or bulk erase is granted only when the arming latch is 1, busy reads 0 and `eng_done` is low. A rejected command leaves the arming latch, the protection level and the lock bit unchanged.
- R5: A granted status write loads bits 3:2 and bit 7 of `wrsr_data` into the register. The other data bits are ignored.
- R6: The sector is the top two address bits. Protection level 0 protects nothing, level 1 protects sector 3, level 2 protects sectors 2 and 3, and level 3 protects every sector. A program or sector erase aimed at a protected sector is rejected.
- R7: A bulk erase is granted only when the protection level is 0.
- R8: When the lock bit is 1 and `wp_n` is 0, a status write is rejected and the arming latch stays set. The protection level and lock bit then cannot change.
- R9: A grant is a one-cycle pulse on the edge after the strobe. At most one grant is high at a time, and busy reads 1 from that same cycle.
- R10: An `eng_done` pulse clears both the busy flag and the arming latch on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Arm-write command strobe |
| cmd_wrdi | input | 1 | Disarm command strobe |
| cmd_wrsr | input | 1 | Status write command strobe |
| cmd_pp | input | 1 | Page program command strobe |
| cmd_se | input | 1 | Sector erase command strobe |
| cmd_be | input | 1 | Bulk erase command strobe |
| cmd_addr | input | ADDR_W | Target byte address of program or sector erase |
| wrsr_data | input | 8 | New status value for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| eng_busy | input | 1 | Cycle engine reports activity |
| eng_done | input | 1 | Cycle engine reports cycle completion |
| grant_wrsr | output | 1 | Status write accepted |
| grant_pp | output | 1 | Page program accepted |
| grant_se | output | 1 | Sector erase accepted |
| grant_be | output | 1 | Bulk erase accepted |
| status_byte | output | 8 | Current status value |

## Verification
On every cycle the assertions check the following:
- Any grant was preceded by an armed latch and an idle register.
- Grants are mutually exclusive and raise busy.
- Bulk erase appears only at protection level 0.
- The lock bit together with a low pin freezes the register.
- A done pulse clears the latch.
- The unused status bits stay 0.

Only the bench scenarios can show that the sector mapping rejects exactly the right addresses at each level. The same holds for the exact bits a status write copies, for the latch surviving a rejected command, and for `eng_busy` suppressing arming commands.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        wrsr_data,
  input  logic              wp_n,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              grant_wrsr,
  output logic              grant_pp,
  output logic              grant_se,
  output logic              grant_be,
  output logic [7:0]        status_byte
);
  localparam int SEC_MSB = ADDR_W - 1;

  logic       wip_q, wel_q, lock_q;
  logic [1:0] lvl_q;
  logic       prot_hit;

  wire       busy   = wip_q | eng_busy;
  wire       idle   = !busy && !eng_done;
  wire       armed  = idle && wel_q;
  wire [1:0] sector = cmd_addr[SEC_MSB -: 2];
  wire       frozen = lock_q && !wp_n;

  always_comb begin
    case (lvl_q)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = (sector == 2'd3);
      2'd2:    prot_hit = sector[1];
      default: prot_hit = 1'b1;
    endcase
  end

  wire ok_wrsr = armed && cmd_wrsr && !frozen;
  wire ok_pp   = armed && cmd_pp && !prot_hit;
  wire ok_se   = armed && cmd_se && !prot_hit;
  wire ok_be   = armed && cmd_be && (lvl_q == 2'd0);
  wire ok_any  = ok_wrsr | ok_pp | ok_se | ok_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q      <= 1'b0;
      wel_q      <= 1'b0;
      lock_q     <= 1'b0;
      lvl_q      <= 2'd0;
      grant_wrsr <= 1'b0;
      grant_pp   <= 1'b0;
      grant_se   <= 1'b0;
      grant_be   <= 1'b0;
    end else begin
      grant_wrsr <= ok_wrsr;
      grant_pp   <= ok_pp;
      grant_se   <= ok_se;
      grant_be   <= ok_be;
      if (eng_done) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end else if (idle) begin
        if (cmd_wren)      wel_q <= 1'b1;
        else if (cmd_wrdi) wel_q <= 1'b0;
        if (ok_any) wip_q <= 1'b1;
        if (ok_wrsr) begin
          lvl_q  <= wrsr_data[3:2];
          lock_q <= wrsr_data[7];
        end
      end
    end
  end

  assign status_byte = {lock_q, 3'b000, lvl_q, wel_q, busy};
endmodule

// File: rtl/flash_status_guard_chk.sv
module flash_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       eng_done,
  input logic       grant_wrsr,
  input logic       grant_pp,
  input logic       grant_se,
  input logic       grant_be,
  input logic [7:0] status_byte
);
  wire any_grant = grant_wrsr | grant_pp | grant_se | grant_be;

  // R4
  grant_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_grant |-> ($past(status_byte[1]) && !$past(status_byte[0])));

  // R9
  grant_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_wrsr, grant_pp, grant_se, grant_be}));

  // R9
  grant_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_grant |-> status_byte[0]);

  // R7
  bulk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_be |-> ($past(status_byte[3:2]) == 2'd0));

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wp_n) && $past(status_byte[7])) |-> $stable(status_byte[7:2]));

  // R10
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !status_byte[1]);

  // R2
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000);
endmodule

bind flash_status_guard flash_status_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .eng_done(eng_done),
  .grant_wrsr(grant_wrsr), .grant_pp(grant_pp), .grant_se(grant_se),
  .grant_be(grant_be), .status_byte(status_byte)
);

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;
  localparam int ADDR_W = 17;
  localparam int C_NONE = 0, C_WREN = 1, C_WRDI = 2, C_WRSR = 3, C_PP = 4, C_SE = 5, C_BE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0] wrsr_data = 8'h00;
  logic wp_n = 1'b1, eng_busy = 1'b0, eng_done = 1'b0;
  logic grant_wrsr, grant_pp, grant_se, grant_be;
  logic [7:0] status_byte;

  int checks = 0, failures = 0;
  bit m_wip = 0, m_wel = 0, m_lock = 0;
  bit [1:0] m_lvl = 0;

  always #4 clk = ~clk;

  flash_status_guard #(.ADDR_W(ADDR_W)) i_flash_status_guard (.*);

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit is_prot(bit [1:0] lvl, bit [1:0] sec);
    case (lvl)
      2'd0: return 1'b0;
      2'd1: return sec == 2'd3;
      2'd2: return sec >= 2'd2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] exp_status(bit busy_in);
    return {m_lock, 3'b000, m_lvl, m_wel, m_wip | busy_in};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one command cycle: drive after a falling edge, evaluate at the next falling edge
  task automatic step(int cmd, logic [ADDR_W-1:0] addr, logic [7:0] data,
                      logic wp, logic done, string tag);
    bit armed;
    bit [3:0] eg;
    cmd_wren = (cmd == C_WREN); cmd_wrdi = (cmd == C_WRDI); cmd_wrsr = (cmd == C_WRSR);
    cmd_pp = (cmd == C_PP); cmd_se = (cmd == C_SE); cmd_be = (cmd == C_BE);
    cmd_addr = addr; wrsr_data = data; wp_n = wp; eng_done = done;
    armed = m_wel && !m_wip && !eng_busy && !done;
    eg = '0;
    eg[3] = armed && cmd == C_WRSR && !(m_lock && !wp);
    eg[2] = armed && cmd == C_PP && !is_prot(m_lvl, addr[ADDR_W-1 -: 2]);
    eg[1] = armed && cmd == C_SE && !is_prot(m_lvl, addr[ADDR_W-1 -: 2]);
    eg[0] = armed && cmd == C_BE && m_lvl == 2'd0;
    if (done) begin
      m_wip = 0; m_wel = 0;
    end else if (!m_wip && !eng_busy) begin
      if (cmd == C_WREN) m_wel = 1;
      if (cmd == C_WRDI) m_wel = 0;
      if (eg != 0) m_wip = 1;
      if (eg[3]) begin m_lvl = data[3:2]; m_lock = data[7]; end
    end
    @(negedge clk);
    check({tag, " grant"}, {grant_wrsr, grant_pp, grant_se, grant_be}, eg);
    check({tag, " status"}, status_byte, exp_status(eng_busy));
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_pp = 0; cmd_se = 0; cmd_be = 0;
    eng_done = 0;
  endtask

  function automatic logic [ADDR_W-1:0] sec_addr(bit [1:0] s);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'($urandom);
    a[ADDR_W-1 -: 2] = s;
    return a;
  endfunction

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R1
    check("R1 status", status_byte, 8'h00);
    check("R1 grants", {grant_wrsr, grant_pp, grant_se, grant_be}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 unarmed program is rejected
    step(C_PP, sec_addr(0), 0, 1, 0, "R4 unarmed");
    // R3 arm and disarm
    step(C_WREN, 0, 0, 1, 0, "R3 wren");
    step(C_WRDI, 0, 0, 1, 0, "R3 wrdi");
    // R5 status write copies only bits 7 and 3:2
    step(C_WREN, 0, 0, 1, 0, "R5 arm");
    step(C_WRSR, 0, 8'h77, 1, 0, "R5 wrsr");
    check("R5 copied bits", status_byte[7:2], 6'b000001);
    // R3 arming ignored while busy
    step(C_WRDI, 0, 0, 1, 0, "R3 wrdi busy");
    check("R3 latch kept while busy", status_byte[1], 1'b1);
    // R10
    step(C_NONE, 0, 0, 1, 1, "R10 done");
    check("R10 cleared", status_byte[1:0], 2'b00);
    // R6 level 1: sector 3 blocked, sector 2 allowed
    step(C_WREN, 0, 0, 1, 0, "R6 arm");
    step(C_SE, sec_addr(3), 0, 1, 0, "R6 sector3 blocked");
    check("R4 latch survives reject", status_byte[1], 1'b1);
    step(C_SE, sec_addr(2), 0, 1, 0, "R6 sector2 allowed");
    step(C_NONE, 0, 0, 1, 1, "R10 done2");
    // R7 bulk erase blocked at nonzero level
    step(C_WREN, 0, 0, 1, 0, "R7 arm");
    step(C_BE, 0, 0, 1, 0, "R7 be blocked");
    // R8 lock set, pin low: status write rejected, latch kept
    step(C_WRSR, 0, 8'h80, 1, 0, "R8 set lock");
    step(C_NONE, 0, 0, 1, 1, "R8 done");
    step(C_WREN, 0, 0, 0, 0, "R8 arm");
    step(C_WRSR, 0, 8'h00, 0, 0, "R8 frozen");
    check("R8 frozen value", status_byte, 8'h82);
    // R8 pin high releases freeze
    step(C_WRSR, 0, 8'h00, 1, 0, "R8 released");
    step(C_NONE, 0, 0, 1, 1, "R8 done2");
    // R7 bulk erase at level 0
    step(C_WREN, 0, 0, 1, 0, "R7 arm0");
    step(C_BE, 0, 0, 1, 0, "R7 be ok");
    // R9 grant lasts one cycle
    step(C_NONE, 0, 0, 1, 0, "R9 pulse end");
    step(C_NONE, 0, 0, 1, 1, "R9 done");
    // R2 external busy reflected, arming ignored
    eng_busy = 1;
    step(C_WREN, 0, 0, 1, 0, "R2 ext busy");
    eng_busy = 0;
    step(C_NONE, 0, 0, 1, 0, "R2 idle");

    // R6 R7 R8 random mix
    for (int i = 0; i < 3000; i++) begin
      int c;
      logic dn;
      c = $urandom_range(0, 6);
      dn = m_wip && ($urandom_range(0, 3) == 0);
      step(dn ? C_NONE : c, ADDR_W'($urandom), 8'($urandom),
           1'($urandom_range(0, 3) != 0), dn, "R4/R6/R7/R8 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule